// File: doc/BRIEF.md
# USB OUT Endpoint Receive Buffer

This block sits between the serial interface engine of a USB device and the CPU for one OUT endpoint. The engine pushes received data bytes one per cycle and then gives a single end-of-packet strobe that carries the packet's data toggle, or an error strobe that abandons the packet. Bytes go into a circular byte store. A completed packet raises a ready flag and publishes its byte count. The CPU then reads the bytes through a one-byte read port and releases the packet. The release is either an explicit clear, or happens by itself when the last byte is read and automatic release is enabled.

The store size comes from the endpoint kind, which is a parameter. A control endpoint uses a small fixed store, a fixed endpoint uses a large store, and a dual endpoint picks its small or large size from a configuration bit. When the configured maximum packet size fits twice in the active store, the block holds two complete packets. The ready flag then dips for exactly one cycle between them, and the visible count moves to the second packet only when the first is released. The block checks the expected DATA0/DATA1 sequence. It asks the engine to NAK while every packet slot is occupied, and it lets the CPU restart the toggle sequence at DATA0.

Top module: `out_ep_rxfifo`

## Requirements
- R1: After reset `pkt_rdy` is 0, `wr_count` is 0, `sie_nak` is 0 and `exp_tog` is 0 (DATA0 expected next).
- R2: A packet whose bytes arrive on `sie_valid` cycles and whose `sie_eop` cycle carries the expected toggle is committed. On the clock edge that ends the `sie_eop` cycle, `pkt_rdy` becomes 1 and `wr_count` takes its byte count. `cpu_rdata` shows the packet's bytes in arrival order, and each `cpu_rd` cycle advances it by one byte. Zero-length packets are committed with a count of 0.
- R3: The active store depth is 16 bytes for the control kind and LARGE_DEPTH for the fixed kind. For the dual kind it is SMALL_DEPTH when `cfg_large` is 0 and LARGE_DEPTH when `cfg_large` is 1 (defaults 32 and 128).
- R4: Two packet slots are used when `cfg_maxp` is at most half the active depth; otherwise one slot is used.
- R5: `sie_nak` is 1 exactly while every slot holds a committed packet. A packet that starts while `sie_nak` is 1 is discarded, and the flag, the count, the stored data and `exp_tog` are all left unchanged.
- R6: A `cpu_clr` cycle while `pkt_rdy` is 1 releases the head packet, and `pkt_rdy` reads 0 after that edge.
- R7: With `cfg_auto_clr` = 1 on a non-control kind, the `cpu_rd` cycle that reads the head packet's last byte releases that packet, exactly as `cpu_clr` would.
- R8: On the control kind `cfg_auto_clr` has no effect, and reading every byte of a packet leaves `pkt_rdy` at 1 until `cpu_clr`.
- R9: With two packets held, `wr_count` keeps the first packet's count while it is read. On its release `pkt_rdy` is 0 for exactly one cycle, then returns to 1, and `wr_count` shows the second packet's count.
- R10: `exp_tog` inverts on every committed packet. A packet whose `sie_tog` (0 = DATA0, 1 = DATA1) differs from `exp_tog` is discarded, with no change to flag, count, data or `exp_tog`.
- R11: Driving `cfg_tog_init` to 1 and then back to 0 sets `exp_tog` to 0 on the edge after the 1-to-0 change, and this takes priority over a commit on that cycle. Holding `cfg_tog_init` at 1 changes nothing.
- R12: A `sie_err` cycle abandons the packet being received. The write position returns to that packet's first byte, and no flag, count or toggle change follows, so the next good packet's data reads back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sie_valid | input | 1 | A received data byte is present this cycle |
| sie_data | input | 8 | Received data byte |
| sie_eop | input | 1 | End-of-packet strobe, one cycle, no data |
| sie_err | input | 1 | Abort strobe for the packet in progress |
| sie_tog | input | 1 | Toggle of the ending packet, 0 = DATA0, 1 = DATA1 |
| sie_nak | output | 1 | All packet slots full; engine must NAK |
| cfg_large | input | 1 | Dual kind only: 1 selects the large store |
| cfg_auto_clr | input | 1 | Release packet on reading its last byte |
| cfg_maxp | input | 8 | Maximum packet size in bytes |
| cfg_tog_init | input | 1 | Toggle restart control, acts on 1-to-0 |
| cpu_rd | input | 1 | Consume the byte on cpu_rdata |
| cpu_clr | input | 1 | Release the head packet |
| cpu_rdata | output | 8 | Next unread byte of the head packet |
| pkt_rdy | output | 1 | A complete packet is available |
| wr_count | output | 8 | Byte count of the head packet |
| exp_tog | output | 1 | Toggle expected on the next packet |

## Verification
Every registered result is due on the single clock edge after its stimulus cycle. This covers the commit at the end of the `sie_eop` cycle, a release by `cpu_clr` or by the final `cpu_rd`, a discard, an abort and a toggle restart. The bench drives inputs on the falling edge and samples one falling edge later, so each check lands one full cycle after the stimulus. The two-packet ready dip is checked on two consecutive falling edges: 0 on the first, 1 on the second. `cpu_rdata` is combinational from the read position and is compared on the falling edge before each `cpu_rd` is applied.

// File: rtl/out_ep_pkg.sv
package out_ep_pkg;

    localparam int DATA_W = 8;
    localparam int CNT_W  = 8;

    typedef enum logic [1:0] {
        EP_CTRL  = 2'd0,
        EP_FIXED = 2'd1,
        EP_DUAL  = 2'd2
    } ep_kind_e;

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] len;
    } pkt_commit_t;

    function automatic int ep_max_depth(ep_kind_e kind, int ctrl_d, int large_d);
        return (kind == EP_CTRL) ? ctrl_d : large_d;
    endfunction

    function automatic int ep_depth(ep_kind_e kind, logic large_sel,
                                    int ctrl_d, int small_d, int large_d);
        int d;
        case (kind)
            EP_CTRL:  d = ctrl_d;
            EP_FIXED: d = large_d;
            default:  d = large_sel ? large_d : small_d;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/out_ep_store.sv
module out_ep_store #(
    parameter int DEPTH = 128,
    parameter int AW    = 7,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/out_ep_wr.sv
module out_ep_wr
    import out_ep_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sie_valid,
    input  logic [DATA_W-1:0] sie_data,
    input  logic              sie_eop,
    input  logic              sie_err,
    input  logic              sie_tog,
    input  logic              tog_init,
    input  logic              full,
    input  logic [AW-1:0]     mask,
    input  logic [CNT_W-1:0]  cap,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output pkt_commit_t       commit,
    output logic              exp_tog
);

    logic [AW-1:0]    wr_ptr, pkt_start;
    logic [CNT_W-1:0] pkt_len;
    logic             in_pkt, drop, tog_q, tinit_q;
    logic             drop_eff, good, init_fall;

    // A packet is judged against slot occupancy at its first byte;
    // a zero-length packet is judged at its end strobe.
    assign drop_eff  = in_pkt ? drop : full;
    assign mem_we    = sie_valid && !sie_err && !sie_eop && !drop_eff && (pkt_len < cap);
    assign good      = sie_eop && !sie_err && !drop_eff && (sie_tog == tog_q);
    assign init_fall = tinit_q && !tog_init;

    assign mem_waddr   = wr_ptr & mask;
    assign mem_wdata   = sie_data;
    assign commit.valid = good;
    assign commit.len   = pkt_len;
    assign exp_tog      = tog_q;

    always_ff @(posedge clk) begin
        tinit_q <= tog_init;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr    <= '0;
            pkt_start <= '0;
            pkt_len   <= '0;
            in_pkt    <= 1'b0;
            drop      <= 1'b0;
            tog_q     <= 1'b0;
        end else begin
            if (sie_err) begin
                wr_ptr  <= pkt_start;
                pkt_len <= '0;
                in_pkt  <= 1'b0;
                drop    <= 1'b0;
            end else if (sie_eop) begin
                if (good) pkt_start <= wr_ptr;
                else      wr_ptr    <= pkt_start;
                pkt_len <= '0;
                in_pkt  <= 1'b0;
                drop    <= 1'b0;
            end else if (sie_valid) begin
                if (!in_pkt) drop <= full;
                in_pkt <= 1'b1;
                if (mem_we) begin
                    wr_ptr  <= (wr_ptr + AW'(1)) & mask;
                    pkt_len <= pkt_len + CNT_W'(1);
                end
            end

            if (init_fall)  tog_q <= 1'b0;
            else if (good)  tog_q <= ~tog_q;
        end
    end

endmodule

// File: rtl/out_ep_pktq.sv
module out_ep_pktq
    import out_ep_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  pkt_commit_t      commit,
    input  logic             cpu_rd,
    input  logic             cpu_clr,
    input  logic             auto_en,
    input  logic [AW-1:0]    mask,
    input  logic [1:0]       slots,
    output logic             full,
    output logic [AW-1:0]    rd_addr,
    output logic             pkt_rdy,
    output logic [CNT_W-1:0] wr_count
);

    logic [1:0]       npk, npk_mid, npk_nx;
    logic [CNT_W-1:0] len0, len1, len0_nx, len1_nx;
    logic [AW-1:0]    rd_base;
    logic [CNT_W-1:0] rd_cnt;
    logic             rdy, rd_ok, last, pop;
    logic [CNT_W-1:0] cnt_q;

    assign rd_ok = rdy && cpu_rd && (rd_cnt < len0);
    assign last  = rd_ok && ((rd_cnt + CNT_W'(1)) == len0);
    assign pop   = rdy && (cpu_clr || (auto_en && last));

    always_comb begin
        npk_mid = npk - {1'b0, pop};
        npk_nx  = npk_mid + {1'b0, commit.valid};
        len0_nx = len0;
        len1_nx = len1;
        if (pop) len0_nx = len1;
        if (commit.valid) begin
            if (npk_mid == 2'd0) len0_nx = commit.len;
            else                 len1_nx = commit.len;
        end
    end

    assign full     = (npk >= slots);
    assign rd_addr  = (rd_base + rd_cnt[AW-1:0]) & mask;
    assign pkt_rdy  = rdy;
    assign wr_count = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            npk     <= '0;
            len0    <= '0;
            len1    <= '0;
            rd_base <= '0;
            rd_cnt  <= '0;
            rdy     <= 1'b0;
            cnt_q   <= '0;
        end else begin
            npk  <= npk_nx;
            len0 <= len0_nx;
            len1 <= len1_nx;
            if (pop) begin
                rd_base <= (rd_base + len0[AW-1:0]) & mask;
                rd_cnt  <= '0;
            end else if (rd_ok) begin
                rd_cnt  <= rd_cnt + CNT_W'(1);
            end
            // A release always shows one cycle of not-ready, even when
            // a second packet is already waiting behind it.
            rdy <= !pop && (npk_nx != 2'd0);
            if (npk_nx != 2'd0) cnt_q <= len0_nx;
        end
    end

endmodule

// File: rtl/out_ep_rxfifo.sv
module out_ep_rxfifo
    import out_ep_pkg::*;
#(
    parameter ep_kind_e KIND        = EP_DUAL,
    parameter int       CTRL_DEPTH  = 16,
    parameter int       SMALL_DEPTH = 32,
    parameter int       LARGE_DEPTH = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sie_valid,
    input  logic [DATA_W-1:0] sie_data,
    input  logic              sie_eop,
    input  logic              sie_err,
    input  logic              sie_tog,
    output logic              sie_nak,
    input  logic              cfg_large,
    input  logic              cfg_auto_clr,
    input  logic [CNT_W-1:0]  cfg_maxp,
    input  logic              cfg_tog_init,
    input  logic              cpu_rd,
    input  logic              cpu_clr,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              pkt_rdy,
    output logic [CNT_W-1:0]  wr_count,
    output logic              exp_tog
);

    localparam int MAX_D = ep_max_depth(KIND, CTRL_DEPTH, LARGE_DEPTH);
    localparam int AW    = $clog2(MAX_D);

    logic [CNT_W-1:0]  depth, half, cap;
    logic [AW-1:0]     mask;
    logic              dbl, auto_en, full;
    logic [1:0]        slots;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr, rd_addr;
    logic [DATA_W-1:0] mem_wdata;
    pkt_commit_t       commit;

    always_comb begin
        depth = CNT_W'(ep_depth(KIND, cfg_large, CTRL_DEPTH, SMALL_DEPTH, LARGE_DEPTH));
        half  = depth >> 1;
        dbl   = (cfg_maxp <= half);
        cap   = dbl ? half : depth;
        slots = dbl ? 2'd2 : 2'd1;
        mask  = AW'(depth - CNT_W'(1));
    end

    generate
        if (KIND == EP_CTRL) begin : g_ctrl
            assign auto_en = 1'b0;
        end else begin : g_data
            assign auto_en = cfg_auto_clr;
        end
    endgenerate

    assign sie_nak = full;

    out_ep_wr #(.AW(AW)) u_wr (
        .clk       (clk),
        .rst       (rst),
        .sie_valid (sie_valid),
        .sie_data  (sie_data),
        .sie_eop   (sie_eop),
        .sie_err   (sie_err),
        .sie_tog   (sie_tog),
        .tog_init  (cfg_tog_init),
        .full      (full),
        .mask      (mask),
        .cap       (cap),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .commit    (commit),
        .exp_tog   (exp_tog)
    );

    out_ep_pktq #(.AW(AW)) u_pktq (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .cpu_rd   (cpu_rd),
        .cpu_clr  (cpu_clr),
        .auto_en  (auto_en),
        .mask     (mask),
        .slots    (slots),
        .full     (full),
        .rd_addr  (rd_addr),
        .pkt_rdy  (pkt_rdy),
        .wr_count (wr_count)
    );

    out_ep_store #(.DEPTH(MAX_D), .AW(AW), .DW(DATA_W)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (cpu_rdata)
    );

endmodule

// File: rtl/out_ep_rxfifo_chk.sv
module out_ep_rxfifo_chk
    import out_ep_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sie_eop,
    input logic             sie_err,
    input logic             sie_tog,
    input logic             sie_nak,
    input logic             cfg_tog_init,
    input logic             cpu_rd,
    input logic             cpu_clr,
    input logic             pkt_rdy,
    input logic [CNT_W-1:0] wr_count,
    input logic             exp_tog
);

    // R6: a software release always takes the flag down on the next edge
    p_clear_drops_rdy_r6: assert property (@(posedge clk) disable iff (rst)
        (pkt_rdy && cpu_clr) |=> !pkt_rdy);

    // R9: the visible count moves only when the head packet is released
    p_count_held_r9: assert property (@(posedge clk) disable iff (rst)
        (pkt_rdy && !cpu_clr && !cpu_rd) |=> $stable(wr_count));

    // R5: without a read or a release no slot can free up
    p_nak_held_r5: assert property (@(posedge clk) disable iff (rst)
        (sie_nak && pkt_rdy && !cpu_clr && !cpu_rd) |=> sie_nak);

    // R10: a packet with the wrong toggle leaves the expected toggle alone
    p_bad_tog_keeps_r10: assert property (@(posedge clk) disable iff (rst)
        (sie_eop && !sie_err && (sie_tog != exp_tog) &&
         !($past(cfg_tog_init) && !cfg_tog_init)) |=> $stable(exp_tog));

    // R11: the 1-to-0 change of the restart control forces DATA0
    p_tog_init_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(cfg_tog_init) && !cfg_tog_init) |=> !exp_tog);

endmodule

bind out_ep_rxfifo out_ep_rxfifo_chk u_chk (.*);

// File: tb/tb_out_ep_rxfifo.sv
module tb_out_ep_rxfifo;
    import out_ep_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sie_valid = 1'b0, sie_eop = 1'b0, sie_err = 1'b0, sie_tog = 1'b0;
    logic [7:0] sie_data = '0;
    logic       cfg_large = 1'b0, cfg_auto_clr = 1'b0, cfg_tog_init = 1'b0;
    logic [7:0] cfg_maxp = 8'd32;
    logic       cpu_rd = 1'b0, cpu_clr = 1'b0;

    logic       sie_nak, pkt_rdy, exp_tog;
    logic [7:0] cpu_rdata, wr_count;
    logic       c_nak, c_rdy, c_tog;
    logic [7:0] c_rdata, c_count;

    int n_checks = 0;
    int n_err    = 0;
    bit etog     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    out_ep_rxfifo #(.KIND(EP_DUAL)) dut (
        .clk(clk), .rst(rst), .sie_valid(sie_valid), .sie_data(sie_data),
        .sie_eop(sie_eop), .sie_err(sie_err), .sie_tog(sie_tog), .sie_nak(sie_nak),
        .cfg_large(cfg_large), .cfg_auto_clr(cfg_auto_clr), .cfg_maxp(cfg_maxp),
        .cfg_tog_init(cfg_tog_init), .cpu_rd(cpu_rd), .cpu_clr(cpu_clr),
        .cpu_rdata(cpu_rdata), .pkt_rdy(pkt_rdy), .wr_count(wr_count), .exp_tog(exp_tog)
    );

    out_ep_rxfifo #(.KIND(EP_CTRL)) dut_ctrl (
        .clk(clk), .rst(rst), .sie_valid(sie_valid), .sie_data(sie_data),
        .sie_eop(sie_eop), .sie_err(sie_err), .sie_tog(sie_tog), .sie_nak(c_nak),
        .cfg_large(cfg_large), .cfg_auto_clr(cfg_auto_clr), .cfg_maxp(cfg_maxp),
        .cfg_tog_init(cfg_tog_init), .cpu_rd(cpu_rd), .cpu_clr(cpu_clr),
        .cpu_rdata(c_rdata), .pkt_rdy(c_rdy), .wr_count(c_count), .exp_tog(c_tog)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // bytes on n cycles, then the end strobe; returns at the sampling edge
    task automatic send(input int n, input bit t, input int base);
        for (int i = 0; i < n; i++) begin
            sie_valid = 1'b1;
            sie_data  = 8'(base + i);
            @(negedge clk);
        end
        sie_valid = 1'b0;
        sie_eop   = 1'b1;
        sie_tog   = t;
        @(negedge clk);
        sie_eop   = 1'b0;
    endtask

    task automatic read_chk(input int n, input int base, input string req);
        for (int i = 0; i < n; i++) begin
            chk(req, int'(cpu_rdata), (base + i) & 255);
            cpu_rd = 1'b1;
            @(negedge clk);
        end
        cpu_rd = 1'b0;
    endtask

    task automatic release_pkt();
        cpu_clr = 1'b1;
        @(negedge clk);
        cpu_clr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 pkt_rdy", int'(pkt_rdy), 0);
        chk("R1 wr_count", int'(wr_count), 0);
        chk("R1 sie_nak", int'(sie_nak), 0);
        chk("R1 exp_tog", int'(exp_tog), 0);

        // R7 / R8: automatic release on the data kind, none on the control kind
        cfg_auto_clr = 1'b1;
        send(4, etog, 8'h40);
        etog ^= 1'b1;
        chk("R2 pkt_rdy", int'(pkt_rdy), 1);
        chk("R8 ctrl pkt_rdy", int'(c_rdy), 1);
        read_chk(4, 8'h40, "R2 data");
        chk("R7 auto release", int'(pkt_rdy), 0);
        chk("R8 ctrl ignores auto", int'(c_rdy), 1);
        cfg_auto_clr = 1'b0;
        release_pkt();
        chk("R8 ctrl software clear", int'(c_rdy), 0);
        chk("R6 release ignored when idle", int'(pkt_rdy), 0);

        // R2 / R4 / R5 / R6: single-slot sweep over every length in the small store
        cfg_large = 1'b0;
        cfg_maxp  = 8'd32;
        for (int len = 0; len <= 32; len++) begin
            send(len, etog, len * 7);
            etog ^= 1'b1;
            chk("R2 ready after end", int'(pkt_rdy), 1);
            chk("R2 count", int'(wr_count), len);
            chk("R5 nak single slot", int'(sie_nak), 1);
            if (len == 5) begin
                send(3, etog, 8'hEE);
                chk("R5 discard keeps count", int'(wr_count), 5);
                chk("R5 discard keeps toggle", int'(exp_tog), int'(etog));
                chk("R5 discard keeps ready", int'(pkt_rdy), 1);
            end
            read_chk(len, len * 7, "R2 data");
            chk("R6 still ready before release", int'(pkt_rdy), 1);
            release_pkt();
            chk("R6 released", int'(pkt_rdy), 0);
            chk("R5 nak cleared", int'(sie_nak), 0);
        end

        // R10: wrong toggle is discarded
        send(6, ~etog, 8'h10);
        chk("R10 wrong toggle no ready", int'(pkt_rdy), 0);
        chk("R10 wrong toggle keeps exp", int'(exp_tog), int'(etog));
        send(2, etog, 8'h20);
        etog ^= 1'b1;
        chk("R10 toggle flips", int'(exp_tog), int'(etog));
        read_chk(2, 8'h20, "R10 data after discard");
        release_pkt();

        // R12: abort rolls the write position back
        for (int i = 0; i < 6; i++) begin
            sie_valid = 1'b1;
            sie_data  = 8'(8'h90 + i);
            @(negedge clk);
        end
        sie_valid = 1'b0;
        sie_err   = 1'b1;
        @(negedge clk);
        sie_err   = 1'b0;
        @(negedge clk);
        chk("R12 no ready after abort", int'(pkt_rdy), 0);
        chk("R12 toggle kept", int'(exp_tog), int'(etog));
        send(3, etog, 8'hA0);
        etog ^= 1'b1;
        chk("R12 count of next packet", int'(wr_count), 3);
        read_chk(3, 8'hA0, "R12 data");
        release_pkt();

        // R11: toggle restart
        if (etog == 1'b0) begin
            send(1, etog, 8'h01);
            etog ^= 1'b1;
            release_pkt();
        end
        cfg_tog_init = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R11 held high no change", int'(exp_tog), 1);
        cfg_tog_init = 1'b0;
        @(negedge clk);
        chk("R11 restart to DATA0", int'(exp_tog), 0);
        etog = 1'b0;

        // R3 / R4: slot count follows depth and maximum packet size
        for (int lg = 0; lg < 2; lg++) begin
            for (int k = 0; k < 6; k++) begin
                int mp;
                int dep;
                mp  = (k < 3) ? (15 + k) : (60 + k);
                dep = lg ? 128 : 32;
                cfg_large = 1'(lg);
                cfg_maxp  = 8'(mp);
                @(negedge clk);
                send(1, etog, 8'h33);
                etog ^= 1'b1;
                chk("R3 R4 nak after one packet", int'(sie_nak), (mp <= dep / 2) ? 0 : 1);
                release_pkt();
                chk("R4 empty again", int'(sie_nak), 0);
            end
        end

        // R9: two packets held in the large store
        cfg_large = 1'b1;
        cfg_maxp  = 8'd64;
        for (int ia = 0; ia < 3; ia++) begin
            for (int ib = 0; ib < 3; ib++) begin
                int la;
                int lb;
                la = (ia == 0) ? 1 : (ia == 1) ? 17 : 64;
                lb = (ib == 0) ? 0 : (ib == 1) ? 5 : 64;
                send(la, etog, la * 3 + 1);
                etog ^= 1'b1;
                chk("R4 one of two slots", int'(sie_nak), 0);
                send(lb, etog, lb * 5 + 2);
                etog ^= 1'b1;
                chk("R5 both slots full", int'(sie_nak), 1);
                chk("R9 first count shown", int'(wr_count), la);
                read_chk(la, la * 3 + 1, "R9 first data");
                chk("R9 count held during read", int'(wr_count), la);
                release_pkt();
                chk("R9 dip", int'(pkt_rdy), 0);
                chk("R9 second count", int'(wr_count), lb);
                @(negedge clk);
                chk("R9 back after one cycle", int'(pkt_rdy), 1);
                read_chk(lb, lb * 5 + 2, "R9 second data");
                release_pkt();
                chk("R6 second released", int'(pkt_rdy), 0);
                @(negedge clk);
                chk("R9 stays empty", int'(pkt_rdy), 0);
            end
        end

        // R7 / R9: automatic release with two packets
        cfg_auto_clr = 1'b1;
        send(10, etog, 8'h50);
        etog ^= 1'b1;
        send(20, etog, 8'h70);
        etog ^= 1'b1;
        read_chk(10, 8'h50, "R7 first data");
        chk("R7 auto dip", int'(pkt_rdy), 0);
        chk("R9 count after auto", int'(wr_count), 20);
        @(negedge clk);
        chk("R9 ready returns", int'(pkt_rdy), 1);
        read_chk(20, 8'h70, "R7 second data");
        chk("R7 auto release last", int'(pkt_rdy), 0);
        @(negedge clk);
        chk("R7 stays empty", int'(pkt_rdy), 0);
        cfg_auto_clr = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule